// File: doc/BRIEF.md
# Capture and Compare Timer Unit

This unit sits beside a free-running 16-bit timer and gives software two ways to use it. In the capture modes it copies the timer value into a capture register when an edge arrives on an external input. That edge can be every falling edge, every rising edge, or every 4th or 16th rising edge. In the compare modes it holds a software-written compare value. On the cycle the timer first equals that value, it drives the output pin high, low or to the other level. It can instead only raise the interrupt flag, or fire a special event that resets the timer and starts an analog conversion.

One 4-bit mode field picks the behaviour. The compare value arrives on a valid/ready write port. Ready is always high, so the port never applies back-pressure: every beat offered with valid high is accepted on that clock edge. Pin level, drive enable, interrupt flag and the two strobes are plain control outputs. The timer itself and the interrupt controller sit outside this block.

Top module: `cc_unit`

## Requirements
- R1: The capture register changes only in capture modes (codes 01xx) and in the off state. In a compare mode, edges on the input leave it unchanged.
- R2: The unit is off for codes 0000, 0001, 0011 and 11xx. While off, the edge following each cycle spent there clears the capture register, the interrupt flag, the pin level and both strobes, and the drive enable is low.
- R3: Code 0101 captures on each rising edge of the input and code 0100 on each falling edge; the opposite edge is ignored. The input passes through two synchronizer flops. The capture register shows the timer value at the third rising clock edge after the input changes.
- R4: Code 0110 captures on every 4th rising input edge, and code 0111 on every 16th.
- R5: Any change of the mode field clears the prescale edge counter.
- R6: On a match, code 0010 toggles the pin level, code 1000 sets it and code 1001 clears it. The drive enable is high in exactly these three codes.
- R7: On a match, code 1010 only sets the interrupt flag. The pin level is unchanged and the drive enable is low.
- R8: On a match, code 1011 sets the flag and pulses the timer-reset strobe for one cycle. The conversion-start strobe pulses with it only when the converter-enable input is high.
- R9: A compare action fires once per match event, on the first cycle the timer equals the compare value. While the two stay equal, no further action follows.
- R10: A capture or a compare action sets the interrupt flag. The flag stays set until the clear strobe is high on a clock edge. If a set and a clear fall on the same edge, the set wins.
- R11: The compare write port accepts data on every cycle that valid is high, since ready is always high. The written value is used for matching from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 4 | Mode field |
| tmr_i | input | 16 | Current timer value |
| pin_i | input | 1 | External capture input (asynchronous) |
| cmp_valid_i | input | 1 | Compare write valid |
| cmp_ready_o | output | 1 | Compare write ready (always high) |
| cmp_data_i | input | 16 | Compare write data |
| flag_clr_i | input | 1 | Software clear of the interrupt flag |
| adc_en_i | input | 1 | Converter enabled |
| cap_o | output | 16 | Capture register |
| flag_o | output | 1 | Interrupt flag |
| pin_o | output | 1 | Output pin level |
| pin_oe_o | output | 1 | Output pin drive enable |
| tmr_rst_o | output | 1 | Timer-reset strobe |
| conv_start_o | output | 1 | Conversion-start strobe |

## Verification
A wrong prescale count shows up at the next 4th or 16th input pulse. The capture register then updates one pulse early or late, so at most 16 input pulses expose it. A stale match-history bit shows up on the very next match cycle: the pin toggles or the flag and strobe repeat while the timer sits on the compare value, or the first match is missed. A bad synchronizer depth moves the capture by a whole clock, which shows when the capture register is sampled exactly three edges after the input changes.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam logic [3:0] MODE_OFF      = 4'b0000;
  localparam logic [3:0] MODE_TOGGLE   = 4'b0010;
  localparam logic [3:0] MODE_CAP_FALL = 4'b0100;
  localparam logic [3:0] MODE_CAP_RISE = 4'b0101;
  localparam logic [3:0] MODE_CAP_4    = 4'b0110;
  localparam logic [3:0] MODE_CAP_16   = 4'b0111;
  localparam logic [3:0] MODE_SET      = 4'b1000;
  localparam logic [3:0] MODE_CLEAR    = 4'b1001;
  localparam logic [3:0] MODE_SOFT     = 4'b1010;
  localparam logic [3:0] MODE_SPECIAL  = 4'b1011;

  function automatic logic is_capture(input logic [3:0] m);
    return m[3:2] == 2'b01;
  endfunction

  function automatic logic is_compare(input logic [3:0] m);
    return (m == MODE_TOGGLE) || (m[3:2] == 2'b10);
  endfunction

  function automatic logic is_off(input logic [3:0] m);
    return !is_capture(m) && !is_compare(m);
  endfunction

  function automatic logic drives_pin(input logic [3:0] m);
    return (m == MODE_TOGGLE) || (m == MODE_SET) || (m == MODE_CLEAR);
  endfunction
endpackage

// File: rtl/cc_sync_edge.sv
module cc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  // sr[STAGES-1] is the synchronized level, sr[STAGES] its previous value
  logic [STAGES:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else        sr <= {sr[STAGES-1:0], pin_i};
  end

  assign rise_o = sr[STAGES-1] & ~sr[STAGES];
  assign fall_o = ~sr[STAGES-1] & sr[STAGES];
endmodule

// File: rtl/cc_prescale.sv
module cc_prescale
  import cc_pkg::*;
#(
  parameter int FAST = 4,
  parameter int SLOW = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] mode_i,
  input  logic       rise_i,
  output logic       fire_o
);
  localparam int CW = $clog2(SLOW);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic [3:0]    mode_q;
  logic          pre_mode, steady, at_lim;

  assign pre_mode = (mode_i == MODE_CAP_4) || (mode_i == MODE_CAP_16);
  assign steady   = (mode_i == mode_q);
  assign lim      = (mode_i == MODE_CAP_16) ? CW'(SLOW - 1) : CW'(FAST - 1);
  assign at_lim   = (cnt == lim);
  assign fire_o   = pre_mode & steady & rise_i & at_lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_OFF;
      cnt    <= '0;
    end else begin
      mode_q <= mode_i;
      if (!pre_mode || !steady) cnt <= '0;
      else if (rise_i)          cnt <= at_lim ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cc_compare.sv
module cc_compare #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         off_i,
  input  logic [W-1:0] tmr_i,
  input  logic [W-1:0] cmp_i,
  output logic         hit_o
);
  logic eq, eq_q;

  assign eq    = (tmr_i == cmp_i);
  assign hit_o = eq & ~eq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     eq_q <= 1'b0;
    else if (off_i) eq_q <= 1'b0;
    else            eq_q <= eq;
  end
endmodule

// File: rtl/cc_unit.sv
module cc_unit
  import cc_pkg::*;
#(
  parameter int TMR_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int PS_FAST     = 4,
  parameter int PS_SLOW     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       mode_i,
  input  logic [TMR_W-1:0] tmr_i,
  input  logic             pin_i,
  input  logic             cmp_valid_i,
  output logic             cmp_ready_o,
  input  logic [TMR_W-1:0] cmp_data_i,
  input  logic             flag_clr_i,
  input  logic             adc_en_i,
  output logic [TMR_W-1:0] cap_o,
  output logic             flag_o,
  output logic             pin_o,
  output logic             pin_oe_o,
  output logic             tmr_rst_o,
  output logic             conv_start_o
);
  logic [TMR_W-1:0] cmp_q, cap_q;
  logic flag_q, pin_q, rst_q, conv_q;
  logic rise, fall, fire, hit, off, cap_ev, cmp_ev, special;

  assign off = is_off(mode_i);

  cc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .rise_o(rise), .fall_o(fall)
  );

  cc_prescale #(.FAST(PS_FAST), .SLOW(PS_SLOW)) u_pre (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .rise_i(rise), .fire_o(fire)
  );

  cc_compare #(.W(TMR_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .off_i(off), .tmr_i(tmr_i), .cmp_i(cmp_q),
    .hit_o(hit)
  );

  assign cap_ev  = ((mode_i == MODE_CAP_FALL) & fall)
                 | ((mode_i == MODE_CAP_RISE) & rise)
                 | fire;
  assign cmp_ev  = is_compare(mode_i) & hit;
  assign special = cmp_ev & (mode_i == MODE_SPECIAL);

  // compare write port: never stalls
  assign cmp_ready_o = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cmp_q <= '0;
    else if (cmp_valid_i) cmp_q <= cmp_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
      pin_q  <= 1'b0;
      rst_q  <= 1'b0;
      conv_q <= 1'b0;
    end else if (off) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
      pin_q  <= 1'b0;
      rst_q  <= 1'b0;
      conv_q <= 1'b0;
    end else begin
      if (cap_ev) cap_q <= tmr_i;
      if (cap_ev || cmp_ev) flag_q <= 1'b1;
      else if (flag_clr_i)  flag_q <= 1'b0;
      if (cmp_ev) begin
        case (mode_i)
          MODE_TOGGLE: pin_q <= ~pin_q;
          MODE_SET:    pin_q <= 1'b1;
          MODE_CLEAR:  pin_q <= 1'b0;
          default:     pin_q <= pin_q;
        endcase
      end
      rst_q  <= special;
      conv_q <= special & adc_en_i;
    end
  end

  assign cap_o        = cap_q;
  assign flag_o       = flag_q;
  assign pin_o        = pin_q;
  assign pin_oe_o     = drives_pin(mode_i);
  assign tmr_rst_o    = rst_q;
  assign conv_start_o = conv_q;
endmodule

// File: rtl/cc_unit_chk.sv
module cc_unit_chk
  import cc_pkg::*;
#(
  parameter int TMR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       mode_i,
  input logic             flag_clr_i,
  input logic [TMR_W-1:0] cap_o,
  input logic             flag_o,
  input logic             pin_o,
  input logic             tmr_rst_o,
  input logic             conv_start_o
);
  // R1: no capture outside capture modes
  a_r1_cap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_capture(mode_i) && !is_off(mode_i)) |=> $stable(cap_o));

  // R2: off state clears the unit
  a_r2_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    is_off(mode_i) |=> (cap_o == '0) && !flag_o && !pin_o && !tmr_rst_o && !conv_start_o);

  // R7: flag-only mode leaves the pin level alone
  a_r7_pin_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_SOFT) |=> (pin_o == $past(pin_o)));

  // R8: conversion start only alongside the timer reset
  a_r8_conv_with_rst: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |-> tmr_rst_o);

  // R9: strobe lasts one cycle
  a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_rst_o |=> !tmr_rst_o);

  // R10: flag is sticky without a clear
  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !flag_clr_i && !is_off(mode_i)) |=> flag_o);
endmodule

bind cc_unit cc_unit_chk #(.TMR_W(TMR_W)) u_chk (.*);

// File: tb/sim_cc_unit.sv
`timescale 1ns/1ps
module sim_cc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  mode_i = 4'b0000;
  logic [15:0] tmr_i = '0;
  logic        pin_i = 1'b0;
  logic        cmp_valid_i = 1'b0;
  logic        cmp_ready_o;
  logic [15:0] cmp_data_i = '0;
  logic        flag_clr_i = 1'b0;
  logic        adc_en_i = 1'b1;
  logic [15:0] cap_o;
  logic        flag_o, pin_o, pin_oe_o, tmr_rst_o, conv_start_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  cc_unit u0 (.*);

  // [23:20] mode, [19:4] timer, [3] clear, [2] pin, [1] flag, [0] reset strobe
  localparam int NV = 15;
  localparam logic [23:0] VEC [NV] = '{
    {4'b1000, 16'h1233, 1'b0, 1'b0, 1'b0, 1'b0},
    {4'b1000, 16'h1234, 1'b0, 1'b1, 1'b1, 1'b0},
    {4'b1000, 16'h1234, 1'b0, 1'b1, 1'b1, 1'b0},
    {4'b1000, 16'h1235, 1'b1, 1'b1, 1'b0, 1'b0},
    {4'b1001, 16'h1234, 1'b0, 1'b0, 1'b1, 1'b0},
    {4'b1001, 16'h1234, 1'b1, 1'b0, 1'b0, 1'b0},
    {4'b0010, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0},
    {4'b0010, 16'h1234, 1'b0, 1'b1, 1'b1, 1'b0},
    {4'b1010, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0},
    {4'b1010, 16'h1234, 1'b0, 1'b1, 1'b1, 1'b0},
    {4'b1011, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0},
    {4'b1011, 16'h1234, 1'b0, 1'b1, 1'b1, 1'b1},
    {4'b1011, 16'h1234, 1'b0, 1'b1, 1'b1, 1'b0},
    {4'b0010, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0},
    {4'b0010, 16'h1234, 1'b0, 1'b0, 1'b1, 1'b0}
  };

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic [15:0] t);
    tmr_i = t;
    pin_i = 1'b1;
    repeat (3) step();
    pin_i = 1'b0;
    repeat (3) step();
  endtask

  task automatic write_cmp(input logic [15:0] v);
    cmp_valid_i = 1'b1;
    cmp_data_i  = v;
    step();
    cmp_valid_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // reset state
    chk("R2 reset cap", 32'(cap_o), 0);
    chk("R2 reset flag", 32'(flag_o), 0);
    chk("R2 reset pin", 32'(pin_o), 0);
    chk("R2 reset oe", 32'(pin_oe_o), 0);
    chk("R8 reset strobe", 32'(tmr_rst_o), 0);
    chk("R11 ready", 32'(cmp_ready_o), 1);

    // vector table: compare actions
    write_cmp(16'h1234);
    step();
    for (int i = 0; i < NV; i++) begin
      mode_i     = VEC[i][23:20];
      tmr_i      = VEC[i][19:4];
      flag_clr_i = VEC[i][3];
      step();
      chk($sformatf("R6 R9 row%0d pin", i), 32'(pin_o), 32'(VEC[i][2]));
      chk($sformatf("R10 row%0d flag", i), 32'(flag_o), 32'(VEC[i][1]));
      chk($sformatf("R8 row%0d tmr_rst", i), 32'(tmr_rst_o), 32'(VEC[i][0]));
      chk($sformatf("R8 row%0d conv", i), 32'(conv_start_o), 32'(VEC[i][0]));
      chk($sformatf("R6 R7 row%0d oe", i), 32'(pin_oe_o),
          32'(VEC[i][23:20] == 4'b0010 || VEC[i][23:20] == 4'b1000 || VEC[i][23:20] == 4'b1001));
    end
    flag_clr_i = 1'b0;

    // R11: new compare value takes effect
    mode_i = 4'b0000; tmr_i = 16'h0000;
    step();
    write_cmp(16'h0050);
    mode_i = 4'b1000;
    step();
    tmr_i = 16'h0050;
    step();
    chk("R11 new compare pin", 32'(pin_o), 1);
    chk("R11 new compare flag", 32'(flag_o), 1);

    // R10: set wins over clear on the same edge
    tmr_i = 16'h0000;
    step();
    tmr_i = 16'h0050; flag_clr_i = 1'b1;
    step();
    flag_clr_i = 1'b0;
    chk("R10 set beats clear", 32'(flag_o), 1);

    // R8: converter disabled
    adc_en_i = 1'b0; mode_i = 4'b1011; tmr_i = 16'h0000;
    step();
    tmr_i = 16'h0050;
    step();
    chk("R8 rst without adc", 32'(tmr_rst_o), 1);
    chk("R8 no conv without adc", 32'(conv_start_o), 0);
    adc_en_i = 1'b1;

    // R2: reserved code acts as off
    mode_i = 4'b0011;
    step();
    chk("R2 reserved pin", 32'(pin_o), 0);
    chk("R2 reserved flag", 32'(flag_o), 0);
    chk("R2 reserved oe", 32'(pin_oe_o), 0);

    // R3: rising-edge capture, three clock edges of latency
    mode_i = 4'b0101; tmr_i = 16'hABCD; pin_i = 1'b1;
    step(); step();
    chk("R3 not yet captured", 32'(cap_o), 0);
    step();
    chk("R3 rise capture", 32'(cap_o), 32'h0000ABCD);
    chk("R10 capture flag", 32'(flag_o), 1);
    tmr_i = 16'h1111; pin_i = 1'b0;
    repeat (3) step();
    chk("R3 rise mode ignores fall", 32'(cap_o), 32'h0000ABCD);

    // R3: falling-edge capture
    mode_i = 4'b0100;
    pulse(16'h2222);
    chk("R3 fall capture", 32'(cap_o), 32'h00002222);

    // R1: compare mode ignores input edges
    mode_i = 4'b1000; tmr_i = 16'h3333;
    step();
    pulse(16'h3333);
    chk("R1 no capture in compare", 32'(cap_o), 32'h00002222);

    // R4: every 4th rising edge
    mode_i = 4'b0110;
    step();
    for (int i = 1; i <= 3; i++) pulse(16'(100 + i));
    chk("R4 div4 before 4th", 32'(cap_o), 32'h00002222);
    pulse(16'd104);
    chk("R4 div4 capture", 32'(cap_o), 32'd104);

    // R4: every 16th rising edge
    mode_i = 4'b0111;
    step();
    for (int i = 1; i <= 15; i++) pulse(16'(200 + i));
    chk("R4 div16 before 16th", 32'(cap_o), 32'd104);
    pulse(16'd216);
    chk("R4 div16 capture", 32'(cap_o), 32'd216);

    // R5: mode change clears the prescale counter
    mode_i = 4'b0110;
    step();
    pulse(16'd300);
    pulse(16'd301);
    mode_i = 4'b0111;
    step();
    mode_i = 4'b0110;
    step();
    pulse(16'd302);
    pulse(16'd303);
    chk("R5 counter restarted", 32'(cap_o), 32'd216);
    pulse(16'd304);
    pulse(16'd305);
    chk("R5 capture after restart", 32'(cap_o), 32'd305);

    // R2: PWM-range code is off and ignores edges
    mode_i = 4'b1100;
    step();
    chk("R2 off clears cap", 32'(cap_o), 0);
    pulse(16'h4444);
    chk("R2 off no capture", 32'(cap_o), 0);
    chk("R2 off no flag", 32'(flag_o), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule